// File: doc/BRIEF.md
# ECC Error Statistics With Threshold

This block gathers the single-bit and double-bit error events that an ECC decoder reports for each pseudo channel of a memory controller. For every channel it keeps two saturating counters, one per error class, and a single-bit threshold status flag. The flag clears itself when software reads it.

Single-bit errors are counted only after a programmable threshold has been passed. Each channel has a hidden pre-count that absorbs the first events, up to the threshold. Every single-bit event after that increments the visible counter and sets the flag. Double-bit errors are never gated.

A level-sensitive clear register holds all counters and pre-counts at zero for as long as it is set. A small register bus gives access to the threshold, the clear control, the counters and the flags. The bus has write and read strobes, an address and registered read data.

Top module: `ecc_err_stats`

## Requirements
- R1: After reset, every counter, every status flag, the threshold register and the clear register read as zero, and `thresh_irq_o` is all zero.
- R2: Each counter stops at 255 and holds that value while further events of its class arrive.
- R3: While the clear register (address 1, bit 0) holds 1, all counters read zero and error events have no effect on them. The status flags are not changed by the clear. Counting resumes once the register returns to 0.
- R4: With a threshold T (address 0, 8 bits), a channel's first T single-bit events leave its visible single-bit counter at its value. Each later single-bit event increments that counter by one and sets the channel's status flag, visible on `thresh_irq_o[c]`. When T is 0, the first event already counts.
- R5: A read of channel c's flag address returns the flag in bit 0 on the cycle after the strobe, and the flag is 0 from then on unless a new event sets it.
- R6: Every double-bit event of a channel increments that channel's double-bit counter, whatever the threshold is.
- R7: If a counted single-bit event falls in the same cycle as a read of that channel's flag, the read returns the old value and the flag stays 1.
- R8: A single-bit event and a double-bit event on one channel in the same cycle increment both counters.
- R9: The clear also resets the hidden pre-counts, so after release the channel again absorbs T single-bit events before counting.
- R10: Register map: address 0 is the threshold and address 1 the clear bit, both read and write. For channel c, address 4c+4 holds the single-bit count, 4c+5 the double-bit count and 4c+6 the flag; these addresses are read-only and ignore writes. Unmapped addresses read 0. Read data is registered and appears the cycle after `bus_rd_i`.
- R11: Channels are independent: events on one channel never change another channel's counters or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_err_i | input | NCH | Single-bit error event per channel, one per cycle |
| db_err_i | input | NCH | Double-bit error event per channel, one per cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | CNT_W | Register write data |
| bus_rdata_o | output | CNT_W | Registered read data |
| thresh_irq_o | output | NCH | Single-bit threshold status flag per channel |

## Verification
Two pairs of functions can meet in one cycle. The first is a flag read and a new counted single-bit event on the same channel. The bench provokes it by raising that channel's single-bit input in the same cycle as the read strobe. It then checks that the read returns the old flag, that the flag stays set afterwards and that the counter advanced. The second pair is a single-bit and a double-bit event on one channel, driven together, after which both counters must have moved by exactly one.

// File: rtl/ecc_stats_pkg.sv
`timescale 1ns/1ps
package ecc_stats_pkg;
  localparam int THR_ADDR  = 0;
  localparam int CLR_ADDR  = 1;
  localparam int CH_BASE   = 4;
  localparam int CH_STRIDE = 4;
  localparam int SB_OFS    = 0;
  localparam int DB_OFS    = 1;
  localparam int FLAG_OFS  = 2;

  function automatic int chan_addr(input int ch, input int ofs);
    return CH_BASE + ch * CH_STRIDE + ofs;
  endfunction
endpackage

// File: rtl/ecc_sat_counter.sv
`timescale 1ns/1ps
module ecc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc && q != MAX) q <= q + 1'b1;
  end
endmodule

// File: rtl/ecc_chan_stats.sv
`timescale 1ns/1ps
module ecc_chan_stats #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          sb_i,
  input  logic          db_i,
  input  logic          flag_rd_i,
  output logic [CW-1:0] cnt_sb_o,
  output logic [CW-1:0] cnt_db_o,
  output logic          flag_o
);
  logic [CW-1:0] pre_q;
  logic          armed, ev_sb, pre_inc, sb_inc, db_inc;

  // pre-count absorbs events until it has reached the threshold
  assign armed   = (pre_q >= thresh_i);
  assign ev_sb   = sb_i & ~clr_i;
  assign pre_inc = ev_sb & ~armed;
  assign sb_inc  = ev_sb & armed;
  assign db_inc  = db_i & ~clr_i;

  ecc_sat_counter #(.W(CW)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_i), .inc(pre_inc), .q(pre_q)
  );
  ecc_sat_counter #(.W(CW)) u_sb (
    .clk(clk), .rst(rst), .clr(clr_i), .inc(sb_inc), .q(cnt_sb_o)
  );
  ecc_sat_counter #(.W(CW)) u_db (
    .clk(clk), .rst(rst), .clr(clr_i), .inc(db_inc), .q(cnt_db_o)
  );

  // a counted event wins over the read-clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            flag_o <= 1'b0;
    else if (sb_inc)    flag_o <= 1'b1;
    else if (flag_rd_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/ecc_reg_if.sv
`timescale 1ns/1ps
module ecc_reg_if
  import ecc_stats_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 8,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [CW-1:0]     bus_wdata_i,
  input  logic [NCH*CW-1:0] cnt_sb_i,
  input  logic [NCH*CW-1:0] cnt_db_i,
  input  logic [NCH-1:0]    flag_i,
  output logic [CW-1:0]     thresh_o,
  output logic              clr_o,
  output logic [NCH-1:0]    flag_rd_o,
  output logic [CW-1:0]     rdata_o
);
  logic [CW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == AW'(THR_ADDR)) rd_mux = thresh_o;
    if (bus_addr_i == AW'(CLR_ADDR)) rd_mux = CW'(clr_o);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr_i == AW'(chan_addr(c, SB_OFS)))   rd_mux = cnt_sb_i[c*CW +: CW];
      if (bus_addr_i == AW'(chan_addr(c, DB_OFS)))   rd_mux = cnt_db_i[c*CW +: CW];
      if (bus_addr_i == AW'(chan_addr(c, FLAG_OFS))) rd_mux = CW'(flag_i[c]);
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      flag_rd_o[c] = bus_rd_i && (bus_addr_i == AW'(chan_addr(c, FLAG_OFS)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_o <= '0;
      clr_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (bus_wr_i && bus_addr_i == AW'(THR_ADDR)) thresh_o <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == AW'(CLR_ADDR)) clr_o    <= bus_wdata_i[0];
      if (bus_rd_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ecc_err_stats.sv
`timescale 1ns/1ps
module ecc_err_stats #(
  parameter int NCH    = 2,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    sb_err_i,
  input  logic [NCH-1:0]    db_err_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic [NCH-1:0]    thresh_irq_o
);
  logic [CNT_W-1:0]     thresh_q;
  logic                 clr_q;
  logic [NCH-1:0]       flag_rd;
  logic [NCH*CNT_W-1:0] cnt_sb_all;
  logic [NCH*CNT_W-1:0] cnt_db_all;
  logic [NCH-1:0]       flag_all;

  ecc_reg_if #(.NCH(NCH), .CW(CNT_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .cnt_sb_i(cnt_sb_all), .cnt_db_i(cnt_db_all), .flag_i(flag_all),
    .thresh_o(thresh_q), .clr_o(clr_q), .flag_rd_o(flag_rd),
    .rdata_o(bus_rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ecc_chan_stats #(.CW(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .clr_i(clr_q), .thresh_i(thresh_q),
      .sb_i(sb_err_i[c]), .db_i(db_err_i[c]), .flag_rd_i(flag_rd[c]),
      .cnt_sb_o(cnt_sb_all[c*CNT_W +: CNT_W]),
      .cnt_db_o(cnt_db_all[c*CNT_W +: CNT_W]),
      .flag_o(flag_all[c])
    );
  end

  assign thresh_irq_o = flag_all;
endmodule

// File: rtl/ecc_err_stats_chk.sv
`timescale 1ns/1ps
module ecc_err_stats_chk
  import ecc_stats_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 8,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    sb_err_i,
  input logic [NCH-1:0]    db_err_i,
  input logic              bus_rd_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic              clr_q,
  input logic [NCH*CW-1:0] cnt_sb_all,
  input logic [NCH*CW-1:0] cnt_db_all,
  input logic [NCH-1:0]    flag_all
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  // R3: a set clear register forces every counter to zero on the next cycle
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (cnt_sb_all == '0 && cnt_db_all == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam logic [AW-1:0] FADDR = AW'(chan_addr(c, FLAG_OFS));

    // R2: a full counter holds its value
    a_r2_sb_hold: assert property (@(posedge clk) disable iff (rst)
      (cnt_sb_all[c*CW +: CW] == MAXV && !clr_q) |=> cnt_sb_all[c*CW +: CW] == MAXV);
    a_r2_db_hold: assert property (@(posedge clk) disable iff (rst)
      (cnt_db_all[c*CW +: CW] == MAXV && !clr_q) |=> cnt_db_all[c*CW +: CW] == MAXV);

    // R4: the visible counter moves by at most one per cycle
    a_r4_sb_step: assert property (@(posedge clk) disable iff (rst)
      !clr_q |=> (cnt_sb_all[c*CW +: CW] - $past(cnt_sb_all[c*CW +: CW])) <= CW'(1));

    // R4: the flag only rises after a single-bit event outside clear
    a_r4_flag_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_all[c]) |-> $past(sb_err_i[c] && !clr_q));

    // R5: the flag only falls after a read of its own address
    a_r5_flag_rdclr: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_all[c]) |-> $past(bus_rd_i && bus_addr_i == FADDR));

    // R6: the double-bit counter only grows on a double-bit event
    a_r6_db_cause: assert property (@(posedge clk) disable iff (rst)
      (cnt_db_all[c*CW +: CW] != $past(cnt_db_all[c*CW +: CW]) && !$past(clr_q))
        |-> $past(db_err_i[c]));
  end
endmodule

bind ecc_err_stats ecc_err_stats_chk #(.NCH(NCH), .CW(CNT_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sb_err_i(sb_err_i), .db_err_i(db_err_i),
  .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i), .clr_q(clr_q),
  .cnt_sb_all(cnt_sb_all), .cnt_db_all(cnt_db_all), .flag_all(flag_all)
);

// File: tb/ecc_err_stats_tb.sv
`timescale 1ns/1ps
module ecc_err_stats_tb;
  import ecc_stats_pkg::*;

  localparam int NCH = 2, CW = 8, AW = 4;
  localparam time CLK_P = 20ns;

  logic           clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] sb = '0, db = '0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [CW-1:0]  wdata = '0;
  logic [CW-1:0]  rdata;
  logic [NCH-1:0] irq;

  int checks = 0, failures = 0;

  ecc_err_stats #(.NCH(NCH), .CNT_W(CW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .sb_err_i(sb), .db_err_i(db),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .thresh_irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [1:0] sb;
    logic [1:0] db;
    logic [7:0] n;
    logic [7:0] e_sb0;
    logic [7:0] e_sb1;
    logic [7:0] e_db0;
    logic [7:0] e_db1;
    logic [1:0] e_irq;
  } vec_t;

  // threshold 3; expected values are cumulative after each row
  localparam vec_t TBL [6] = '{
    '{sb:2'b01, db:2'b00, n:8'd2,  e_sb0:8'd0, e_sb1:8'd0, e_db0:8'd0, e_db1:8'd0,  e_irq:2'b00},
    '{sb:2'b01, db:2'b00, n:8'd1,  e_sb0:8'd0, e_sb1:8'd0, e_db0:8'd0, e_db1:8'd0,  e_irq:2'b00},
    '{sb:2'b01, db:2'b00, n:8'd1,  e_sb0:8'd1, e_sb1:8'd0, e_db0:8'd0, e_db1:8'd0,  e_irq:2'b01},
    '{sb:2'b11, db:2'b11, n:8'd4,  e_sb0:8'd5, e_sb1:8'd1, e_db0:8'd4, e_db1:8'd4,  e_irq:2'b11},
    '{sb:2'b00, db:2'b10, n:8'd10, e_sb0:8'd5, e_sb1:8'd1, e_db0:8'd4, e_db1:8'd14, e_irq:2'b11},
    '{sb:2'b10, db:2'b00, n:8'd5,  e_sb0:8'd5, e_sb1:8'd6, e_db0:8'd4, e_db1:8'd14, e_irq:2'b11}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic run(input logic [1:0] s, input logic [1:0] d, input int n);
    sb = s; db = d;
    repeat (n) @(negedge clk);
    sb = '0; db = '0;
  endtask

  task automatic rdreg(input int a, output int v);
    rd = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd = 1'b0;
    v = int'(rdata);
  endtask

  task automatic wrreg(input int a, input int v);
    wr = 1'b1; addr = AW'(a); wdata = CW'(v);
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state of every mapped register and the flag outputs
    rdreg(THR_ADDR, v); chk("R1 threshold", v, 0);
    rdreg(CLR_ADDR, v); chk("R1 clear", v, 0);
    for (int c = 0; c < NCH; c++) begin
      rdreg(chan_addr(c, SB_OFS), v);   chk("R1 sb count", v, 0);
      rdreg(chan_addr(c, DB_OFS), v);   chk("R1 db count", v, 0);
      rdreg(chan_addr(c, FLAG_OFS), v); chk("R1 flag", v, 0);
    end
    chk("R1 irq", int'(irq), 0);

    // R10: threshold is writable and reads back
    wrreg(THR_ADDR, 3);
    rdreg(THR_ADDR, v); chk("R10 threshold readback", v, 3);

    // R4 R6 R8 R11: table of event patterns
    for (int i = 0; i < 6; i++) begin
      run(TBL[i].sb, TBL[i].db, int'(TBL[i].n));
      rdreg(chan_addr(0, SB_OFS), v); chk("R4 sb count ch0", v, int'(TBL[i].e_sb0));
      rdreg(chan_addr(1, SB_OFS), v); chk("R11 sb count ch1", v, int'(TBL[i].e_sb1));
      rdreg(chan_addr(0, DB_OFS), v); chk("R6 db count ch0", v, int'(TBL[i].e_db0));
      rdreg(chan_addr(1, DB_OFS), v); chk("R8 db count ch1", v, int'(TBL[i].e_db1));
      chk("R4 irq", int'(irq), int'(TBL[i].e_irq));
    end

    // R5: flag read returns 1 then clears
    rdreg(chan_addr(0, FLAG_OFS), v); chk("R5 flag read value", v, 1);
    chk("R5 flag cleared", int'(irq[0]), 0);
    rdreg(chan_addr(0, FLAG_OFS), v); chk("R5 flag second read", v, 0);

    // R7: read of flag in the same cycle as a counted event
    sb = 2'b10;
    rdreg(chan_addr(1, FLAG_OFS), v);
    sb = '0;
    chk("R7 read returns old flag", v, 1);
    chk("R7 flag stays set", int'(irq[1]), 1);
    rdreg(chan_addr(1, SB_OFS), v); chk("R7 counter advanced", v, 7);
    rdreg(chan_addr(1, FLAG_OFS), v); chk("R7 later read", v, 1);
    chk("R5 flag ch1 cleared", int'(irq[1]), 0);

    // R8: simultaneous single and double on one channel
    run(2'b01, 2'b01, 1);
    rdreg(chan_addr(0, SB_OFS), v); chk("R8 sb count", v, 6);
    rdreg(chan_addr(0, DB_OFS), v); chk("R8 db count", v, 5);
    chk("R8 irq ch0", int'(irq[0]), 1);

    // R10: writes to read-only addresses ignored; unmapped reads zero
    wrreg(chan_addr(0, SB_OFS), 8'h55);
    rdreg(chan_addr(0, SB_OFS), v); chk("R10 ro write ignored", v, 6);
    rdreg(3, v); chk("R10 unmapped read", v, 0);

    // R2: saturation
    run(2'b01 & 2'b00, 2'b01, 300);
    rdreg(chan_addr(0, DB_OFS), v); chk("R2 db saturates", v, 255);
    run(2'b00, 2'b01, 1);
    rdreg(chan_addr(0, DB_OFS), v); chk("R2 db holds", v, 255);
    rdreg(chan_addr(1, DB_OFS), v); chk("R11 ch1 db untouched", v, 14);

    // R3: clear holds counters at zero, flags untouched
    wrreg(CLR_ADDR, 1);
    run(2'b11, 2'b11, 5);
    rdreg(chan_addr(0, SB_OFS), v); chk("R3 sb held zero", v, 0);
    rdreg(chan_addr(0, DB_OFS), v); chk("R3 db held zero", v, 0);
    rdreg(chan_addr(1, DB_OFS), v); chk("R3 db ch1 held zero", v, 0);
    rdreg(CLR_ADDR, v); chk("R3 clear readback", v, 1);
    chk("R3 flags untouched", int'(irq), 1);
    wrreg(CLR_ADDR, 0);
    run(2'b00, 2'b10, 2);
    rdreg(chan_addr(1, DB_OFS), v); chk("R3 resumes", v, 2);

    // R9: pre-count restarted by clear (threshold still 3)
    run(2'b01, 2'b00, 3);
    rdreg(chan_addr(0, SB_OFS), v); chk("R9 absorbed again", v, 0);
    run(2'b01, 2'b00, 1);
    rdreg(chan_addr(0, SB_OFS), v); chk("R9 counts after threshold", v, 1);

    // R4: threshold zero counts the first event
    wrreg(THR_ADDR, 0);
    run(2'b10, 2'b00, 1);
    rdreg(chan_addr(1, SB_OFS), v); chk("R4 threshold zero", v, 1);
    chk("R4 irq ch1 set", int'(irq[1]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule